// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 active-high, level-sensitive interrupt sources and fans them out onto four lines: a normal interrupt line and a machine-check line for each of two processor cores. Each line has its own 32-bit enable mask. A line asserts whenever at least one of its enabled sources is high. Nothing is latched, acknowledged or arbitrated. A line falls once its enabled sources have all gone low.

Software reaches the block over a small word-wide register bus. A read-only status word shows the synchronized level of every source. Four mask words, one per line, can be read and written. The bus front end is a two-state machine. `ST_IDLE` accepts any request. Transition `IDLE->RDRESP` is taken on an accepted read. `ST_RDRESP` presents the read data for exactly one cycle. Transition `RDRESP->IDLE` follows unconditionally. An accepted write applies at the accepting edge and the machine stays in `ST_IDLE`.

Top module: `dual_core_irq_hub`

## Requirements
- R1: Status word at offset 0x00: bit i reads the level of `irq_src[i]` once it has passed the two-stage synchronizer, two clock edges after the source changes.
- R2: A write to offset 0x00 changes no register and no output.
- R3: Mask words sit at 0x10 (normal, core 0), 0x14 (normal, core 1), 0x18 (machine check, core 0) and 0x1C (machine check, core 1), and read back the last value written.
- R4: After reset all four mask words read zero, every output line is low, `req_ready` is high and `rsp_valid` is low.
- R5: Each line is registered and, one edge after the status or mask changes, equals the OR over i of (status[i] AND mask[i]) for its own mask.
- R6: No latching: a line drops once every enabled source is low, and it rises again when a source returns.
- R7: Lines are independent: one source enabled in several masks drives all of those lines at once.
- R8: An access to any other offset, including one that is not word aligned, reads zero, and a write to it changes nothing.
- R9: An accepted read gives `rsp_valid` for exactly the next cycle, with `req_ready` low during that cycle. An accepted write gives no response.
- R10: A mask bit of 0 keeps its source off that line even while the source is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_SRC | Level interrupt sources, active high |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| int_core0 | output | 1 | Normal interrupt, core 0 |
| int_core1 | output | 1 | Normal interrupt, core 1 |
| mchk_core0 | output | 1 | Machine-check line, core 0 |
| mchk_core1 | output | 1 | Machine-check line, core 1 |

## Verification
A mask write and a source deassertion can land on the same clock edge. The bench provokes this by dropping a source in the cycle it writes that source's bit into the core-1 mask. The synchronizer still holds the old high level for one more edge, so the core-1 line must pulse for exactly one cycle. The core-0 line must fall on the same edge as that pulse ends. The bench checks the four lines at each of the three falling edges that follow.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;
    localparam int DATA_W        = 32;
    localparam int N_LINES       = 4;
    localparam int OFS_STATUS    = 'h00;
    localparam int OFS_MASK_BASE = 'h10;
    localparam int MASK_STRIDE   = 4;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RDRESP = 1'b1
    } bus_state_t;
endpackage

// File: rtl/irqhub_sync.sv
module irqhub_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/irqhub_regbus.sv
module irqhub_regbus
    import irqhub_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic                             req_write,
    input  logic [ADDR_W-1:0]                req_addr,
    input  logic [DATA_W-1:0]                req_wdata,
    output logic                             rsp_valid,
    output logic [DATA_W-1:0]                rsp_rdata,
    input  logic [NUM_SRC-1:0]               status_i,
    output logic [N_LINES-1:0][NUM_SRC-1:0]  mask_o
);
    bus_state_t                        state_q;
    bus_state_t                        state_d;
    logic [N_LINES-1:0][NUM_SRC-1:0]   mask_q;
    logic [N_LINES-1:0]                hit_mask;
    logic                              hit_status;
    logic                              hit_any;
    logic                              accept;
    logic [DATA_W-1:0]                 rd_sel;
    logic [DATA_W-1:0]                 rdata_q;

    // address decode
    always_comb begin
        hit_status = (req_addr == ADDR_W'(OFS_STATUS));
        for (int k = 0; k < N_LINES; k++) begin
            hit_mask[k] = (req_addr == ADDR_W'(OFS_MASK_BASE + MASK_STRIDE * k));
        end
        hit_any = hit_status | (|hit_mask);
    end

    // read data select, zero for unmapped
    always_comb begin
        rd_sel = '0;
        if (hit_status) rd_sel[NUM_SRC-1:0] = status_i;
        for (int k = 0; k < N_LINES; k++) begin
            if (hit_mask[k]) rd_sel[NUM_SRC-1:0] = mask_q[k];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid && !req_write) state_d = ST_RDRESP;
            ST_RDRESP: state_d = ST_IDLE;
        endcase
    end

    // state-derived outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RDRESP);
    end

    assign accept = req_valid && req_ready;

    // registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            if (req_write) begin
                for (int k = 0; k < N_LINES; k++) begin
                    if (hit_mask[k]) mask_q[k] <= req_wdata[NUM_SRC-1:0];
                end
            end else begin
                rdata_q <= rd_sel;
            end
        end
    end

    assign mask_o    = mask_q;
    assign rsp_rdata = rdata_q;

    // R9: accepted read is answered next cycle
    a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);
    // R9: accepted write gives no response
    a_r9_no_rsp_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !rsp_valid);
    // R9: no new request taken while responding
    a_r9_ready_low_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R2: status write leaves all masks untouched
    a_r2_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && hit_status) |=> $stable(mask_o));
    // R8: unmapped write leaves masks untouched
    a_r8_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !hit_any) |=> $stable(mask_o));
    // R8: unmapped read returns zero
    a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && !hit_any) |=> (rsp_rdata == '0));
endmodule

// File: rtl/irqhub_linegen.sv
module irqhub_linegen
    import irqhub_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              status_i,
    input  logic [N_LINES-1:0][NUM_SRC-1:0] mask_i,
    output logic [N_LINES-1:0]              line_o
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic line_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= 1'b0;
            else        line_q <= |(status_i & mask_i[g]);
        end

        assign line_o[g] = line_q;

        // R10: an all-zero mask keeps the line quiet
        a_r10_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            $past(mask_i[g] == '0) |-> !line_q);
        // R6: no sources high means the line falls, nothing is held
        a_r6_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
            $past(status_i == '0) |-> !line_q);
    end
endmodule

// File: rtl/dual_core_irq_hub.sv
module dual_core_irq_hub
    import irqhub_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               int_core0,
    output logic               int_core1,
    output logic               mchk_core0,
    output logic               mchk_core1
);
    logic [NUM_SRC-1:0]              status_w;
    logic [N_LINES-1:0][NUM_SRC-1:0] mask_w;
    logic [N_LINES-1:0]              lines_w;

    irqhub_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_src),
        .sync_o  (status_w)
    );

    irqhub_regbus #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regbus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .status_i  (status_w),
        .mask_o    (mask_w)
    );

    irqhub_linegen #(.NUM_SRC(NUM_SRC)) u_linegen (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_w),
        .mask_i   (mask_w),
        .line_o   (lines_w)
    );

    assign int_core0  = lines_w[0];
    assign int_core1  = lines_w[1];
    assign mchk_core0 = lines_w[2];
    assign mchk_core1 = lines_w[3];

    // R7: any source enabled in every mask drives all four lines together
    a_r7_shared_source: assert property (@(posedge clk) disable iff (!rst_n)
        $past(|(status_w & mask_w[0] & mask_w[1] & mask_w[2] & mask_w[3]))
        |-> (int_core0 && int_core1 && mchk_core0 && mchk_core1));
endmodule

// File: tb/sim_dual_core_irq_hub.sv
module sim_dual_core_irq_hub;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_src;
    logic        req_valid, req_write;
    logic        req_ready;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        int_core0, int_core1, mchk_core0, mchk_core1;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] bm [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_core_irq_hub u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .int_core0(int_core0), .int_core1(int_core1),
        .mchk_core0(mchk_core0), .mchk_core1(mchk_core1)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] model_lines(input logic [31:0] s);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) r[k] = |(s & bm[k]);
        return r;
    endfunction

    function automatic logic [3:0] lines();
        return {mchk_core1, mchk_core0, int_core1, int_core0};
    endfunction

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected response", {31'd0, rsp_valid}, 32'd0);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (a == 8'h10) bm[0] = d;
        if (a == 8'h14) bm[1] = d;
        if (a == 8'h18) bm[2] = d;
        if (a == 8'h1C) bm[3] = d;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic apply_src(input logic [31:0] s, input string tag);
        irq_src = s;
        settle();
        check(tag, {28'd0, lines()}, {28'd0, model_lines(s)});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; irq_src = '0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        for (int k = 0; k < 4; k++) bm[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset state
        check("R4 lines after reset", {28'd0, lines()}, 32'd0);
        check("R4 ready after reset", {31'd0, req_ready}, 32'd1);
        check("R4 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        for (int k = 0; k < 4; k++) bus_read(8'(8'h10 + 4*k), 32'd0, "R4 mask reset value");

        // R3 mask readback
        bus_write(8'h10, 32'hA5A5_0F0F);
        bus_write(8'h14, 32'h0000_FFFF);
        bus_write(8'h18, 32'h8000_0001);
        bus_write(8'h1C, 32'h1234_5678);
        for (int k = 0; k < 4; k++) bus_read(8'(8'h10 + 4*k), bm[k], "R3 mask readback");

        // R1 status and R5 line function under several patterns
        apply_src(32'h0000_0100, "R5 lines pattern 0100");
        bus_read(8'h00, 32'h0000_0100, "R1 status 0100");
        apply_src(32'h8000_0000, "R5 lines pattern msb");
        bus_read(8'h00, 32'h8000_0000, "R1 status msb");
        apply_src(32'h5A5A_0000, "R5 lines pattern 5A5A");
        apply_src(32'h0000_0001, "R5 lines pattern lsb");

        // R10 cleared mask bit blocks a high source
        for (int k = 0; k < 4; k++) bus_write(8'(8'h10 + 4*k), 32'hFFFF_FFFE);
        irq_src = 32'h0000_0001; settle();
        check("R10 blocked source", {28'd0, lines()}, 32'd0);

        // R7 one source on all four lines
        for (int k = 0; k < 4; k++) bus_write(8'(8'h10 + 4*k), 32'hFFFF_FFFF);
        irq_src = 32'h0000_0040; settle();
        check("R7 shared source", {28'd0, lines()}, 32'hF);

        // R6 level behaviour, no latch
        irq_src = 32'h0; settle();
        check("R6 drop clears lines", {28'd0, lines()}, 32'd0);
        irq_src = 32'h0000_0002; settle();
        check("R6 source returns", {28'd0, lines()}, 32'hF);

        // R2 status write ignored
        irq_src = 32'h0000_000F; settle();
        bus_write(8'h00, 32'h0000_0000);
        bus_read(8'h00, 32'h0000_000F, "R2 status after write");
        bus_read(8'h10, 32'hFFFF_FFFF, "R2 mask after status write");
        check("R2 lines after status write", {28'd0, lines()}, 32'hF);

        // R8 unmapped and misaligned offsets
        bus_write(8'h04, 32'h0);
        bus_write(8'h20, 32'h0);
        bus_write(8'h12, 32'h0);
        bus_write(8'hFC, 32'h0);
        for (int k = 0; k < 4; k++) bus_read(8'(8'h10 + 4*k), 32'hFFFF_FFFF, "R8 masks kept");
        bus_read(8'h04, 32'd0, "R8 read 04");
        bus_read(8'h12, 32'd0, "R8 read misaligned 12");
        bus_read(8'h20, 32'd0, "R8 read 20");
        check("R8 lines kept", {28'd0, lines()}, 32'hF);

        // R5 with R6: mask write and source drop in the same cycle
        bus_write(8'h10, 32'h0000_0020);
        bus_write(8'h14, 32'h0);
        bus_write(8'h18, 32'h0);
        bus_write(8'h1C, 32'h0);
        irq_src = 32'h0000_0020; settle();
        check("R5 combo setup", {28'd0, lines()}, 32'h1);
        irq_src = 32'h0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h14; req_wdata = 32'h0000_0020;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R5 combo edge1", {28'd0, lines()}, 32'h1);
        @(negedge clk);
        check("R5 combo edge2 pulse", {28'd0, lines()}, 32'h3);
        @(negedge clk);
        check("R6 combo edge3 quiet", {28'd0, lines()}, 32'h0);

        repeat (3) @(negedge clk);
        check("R9 every read answered", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule